// File: doc/BRIEF.md
# Interconnect Channel-Filtered Event Counter

This block watches a stream of transaction records taken from one port of an on-chip interconnect and counts those that match a programmed event code and pass a set of qualifiers. Each cycle at most one record is presented. A record carries a valid bit, a 3-bit channel code, a tracetag bit, a 2-bit ring destination indication and an event code. Configuration inputs choose a channel filter, a tracetag-only enable, a ring-channel filter and the event code to match.

The counter is controlled by a two-state machine. `ST_IDLE` holds the count. `ST_RUN` adds qualified hits. The transition `go` (`ST_IDLE` to `ST_RUN`) is taken at any edge where `cnt_en` is high. The transition `halt` (`ST_RUN` to `ST_IDLE`) is taken at any edge where `cnt_en` is low. A synchronous clear empties the count and the sticky wrap flag in either state, and it wins over a hit in the same cycle. The count is 48 bits wide by default. A wrap past all-ones sets a flag that stays set until a clear.

Top module: `icn_evcnt`

## Requirements
- R1: After reset, `cnt_value` is 0, `cnt_wrap` is 0 and the state machine is in `ST_IDLE`.
- R2: Four `cfg_chan` values select one channel. 3'b010 is request, 3'b100 is snoop, 3'b110 is response and 3'b111 is data. With one of these set, a record counts only when `txn_chan` equals `cfg_chan`.
- R3: Any other `cfg_chan` value turns channel filtering off, so records on every channel count.
- R4: When `cfg_tag_only` is 1, only records with `txn_tag` = 1 count. When it is 0, the tracetag bit has no effect.
- R5: `txn_ring[1]` means the record went to the extended ring and `txn_ring[0]` means it went to the normal ring. A `cfg_ring` value of 2'b01 or 2'b11 counts only records with `txn_ring[1]` = 1.
- R6: A `cfg_ring` value of 2'b10 counts only records with `txn_ring[0]` = 1.
- R7: A `cfg_ring` value of 2'b00 applies no ring condition.
- R8: The ring condition applies only when the event code lies in 0x47..0x59 inclusive. Outside that range, `txn_ring` and `cfg_ring` have no effect.
- R9: A record counts only when `txn_valid` = 1 and `txn_event` equals `cfg_event`. The count rises by at most 1 per cycle.
- R10: A hit is added at a clock edge only if `cnt_en` was high at the previous edge, which puts the machine in `ST_RUN`. In `ST_IDLE` the count holds.
- R11: When `cnt_clr` is high at an edge, `cnt_value` and `cnt_wrap` both become 0, even if a hit is present in that cycle.
- R12: A hit that finds the count at all-ones wraps it to 0 and sets `cnt_wrap`. The flag stays set through later counting until a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txn_valid | input | 1 | Transaction record present this cycle |
| txn_chan | input | 3 | Channel code of the record |
| txn_tag | input | 1 | Tracetag bit of the record |
| txn_ring | input | 2 | Ring destination: bit 1 extended, bit 0 normal |
| txn_event | input | EV_W | Event code of the record |
| cfg_chan | input | 3 | Channel filter code |
| cfg_tag_only | input | 1 | Count only tracetagged records |
| cfg_ring | input | 2 | Ring-channel filter code |
| cfg_event | input | EV_W | Event code to count |
| cnt_en | input | 1 | Counting enable, steers the state machine |
| cnt_clr | input | 1 | Synchronous clear of count and wrap flag |
| cnt_value | output | CNT_W | Current count |
| cnt_wrap | output | 1 | Sticky wrap flag |

## Verification
The main sweep covers every channel filter code against every record channel, both tracetag settings against both tag values, and every ring filter code against every ring indication. It runs with event codes at both range edges, just outside each edge, and in the middle of the range, so the sweep shows whether ring filtering turns on and off at the right event codes. Each record is followed by one with a wrong event code and one with valid low, which separates matching on the event code from gating by valid. Short directed sequences place `cnt_en` edges, a clear that coincides with a hit, and a run through the full count range of an 8-bit instance. These show the one-cycle enable delay, clear priority and the sticky wrap.

// File: rtl/icn_evcnt_pkg.sv
package icn_evcnt_pkg;

    // Channel filter codes that select one channel; index 0..3 in no priority order
    localparam logic [3:0][2:0] CHAN_SEL_CODES = {3'b111, 3'b110, 3'b100, 3'b010};
    localparam int CHAN_SEL_N = 4;

    // Ring indication bit positions inside txn_ring
    localparam int RING_EXT_BIT  = 1;
    localparam int RING_NORM_BIT = 0;

    typedef enum logic [1:0] {
        RING_ANY  = 2'd0,
        RING_EXT  = 2'd1,
        RING_NORM = 2'd2
    } ring_mode_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

    function automatic ring_mode_t ring_decode(input logic [1:0] code);
        ring_mode_t m;
        unique case (code)
            2'b00:        m = RING_ANY;
            2'b10:        m = RING_NORM;
            2'b01, 2'b11: m = RING_EXT;
            default:      m = RING_ANY;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/icn_evcnt_qual.sv
module icn_evcnt_qual
    import icn_evcnt_pkg::*;
#(
    parameter int EV_W = 8,
    parameter int RING_EV_LO = 'h47,
    parameter int RING_EV_HI = 'h59
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            txn_valid,
    input  logic [2:0]      txn_chan,
    input  logic            txn_tag,
    input  logic [1:0]      txn_ring,
    input  logic [EV_W-1:0] txn_event,
    input  logic [2:0]      cfg_chan,
    input  logic            cfg_tag_only,
    input  logic [1:0]      cfg_ring,
    input  logic [EV_W-1:0] cfg_event,
    output logic            hit
);

    localparam logic [EV_W-1:0] EV_LO = EV_W'(RING_EV_LO);
    localparam logic [EV_W-1:0] EV_HI = EV_W'(RING_EV_HI);

    logic       chan_known;
    logic       chan_ok;
    logic       tag_ok;
    logic       ev_in_range;
    logic       ring_pass;
    logic       ring_ok;
    logic       ev_ok;
    ring_mode_t ring_mode;

    always_comb begin
        chan_known = 1'b0;
        for (int i = 0; i < CHAN_SEL_N; i++) begin
            if (cfg_chan == CHAN_SEL_CODES[i]) chan_known = 1'b1;
        end
        chan_ok = !chan_known || (txn_chan == cfg_chan);
    end

    always_comb begin
        ring_mode   = ring_decode(cfg_ring);
        ev_in_range = (txn_event >= EV_LO) && (txn_event <= EV_HI);
        unique case (ring_mode)
            RING_ANY:  ring_pass = 1'b1;
            RING_EXT:  ring_pass = txn_ring[RING_EXT_BIT];
            RING_NORM: ring_pass = txn_ring[RING_NORM_BIT];
            default:   ring_pass = 1'b1;
        endcase
        ring_ok = !ev_in_range || ring_pass;
    end

    always_comb begin
        tag_ok = !cfg_tag_only || txn_tag;
        ev_ok  = (txn_event == cfg_event);
        hit    = txn_valid && ev_ok && chan_ok && tag_ok && ring_ok;
    end

    // R4: a record without tracetag never hits in tag-only mode
    a_r4_tag_only: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_tag_only && !txn_tag) |-> !hit);

    // R9: no hit without a valid record
    a_r9_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !txn_valid |-> !hit);

    // R5: extended-ring filter inside the range admits only extended-ring records
    a_r5_ext_ring: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && ev_in_range && cfg_ring[0]) |-> txn_ring[RING_EXT_BIT]);

endmodule

// File: rtl/icn_evcnt_acc.sv
module icn_evcnt_acc #(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    output logic [CNT_W-1:0] value,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
            wrap  <= 1'b0;
        end else if (clr) begin
            value <= '0;
            wrap  <= 1'b0;
        end else if (step) begin
            value <= value + 1'b1;
            if (value == ALL_ONES) wrap <= 1'b1;
        end
    end

    // R11: clear empties count and flag at the next edge
    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (value == '0) && !wrap);

    // R9: count moves by at most one per cycle
    a_r9_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (value == $past(value)) || (value == $past(value) + 1'b1));

    // R12: wrap flag is sticky until a clear
    a_r12_sticky_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !clr) |=> wrap);

endmodule

// File: rtl/icn_evcnt.sv
module icn_evcnt
    import icn_evcnt_pkg::*;
#(
    parameter int CNT_W = 48,
    parameter int EV_W = 8,
    parameter int RING_EV_LO = 'h47,
    parameter int RING_EV_HI = 'h59
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             txn_valid,
    input  logic [2:0]       txn_chan,
    input  logic             txn_tag,
    input  logic [1:0]       txn_ring,
    input  logic [EV_W-1:0]  txn_event,
    input  logic [2:0]       cfg_chan,
    input  logic             cfg_tag_only,
    input  logic [1:0]       cfg_ring,
    input  logic [EV_W-1:0]  cfg_event,
    input  logic             cnt_en,
    input  logic             cnt_clr,
    output logic [CNT_W-1:0] cnt_value,
    output logic             cnt_wrap
);

    run_state_t state;
    run_state_t state_nx;
    logic       hit;
    logic       add_hit;

    icn_evcnt_qual #(
        .EV_W       (EV_W),
        .RING_EV_LO (RING_EV_LO),
        .RING_EV_HI (RING_EV_HI)
    ) u_qual (
        .clk          (clk),
        .rst_n        (rst_n),
        .txn_valid    (txn_valid),
        .txn_chan     (txn_chan),
        .txn_tag      (txn_tag),
        .txn_ring     (txn_ring),
        .txn_event    (txn_event),
        .cfg_chan     (cfg_chan),
        .cfg_tag_only (cfg_tag_only),
        .cfg_ring     (cfg_ring),
        .cfg_event    (cfg_event),
        .hit          (hit)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions: go (IDLE->RUN), halt (RUN->IDLE)
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (cnt_en)  state_nx = ST_RUN;
            ST_RUN:  if (!cnt_en) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs of the machine
    always_comb begin
        add_hit = 1'b0;
        unique case (state)
            ST_IDLE: add_hit = 1'b0;
            ST_RUN:  add_hit = hit;
            default: add_hit = 1'b0;
        endcase
    end

    icn_evcnt_acc #(
        .CNT_W (CNT_W)
    ) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .step  (add_hit),
        .value (cnt_value),
        .wrap  (cnt_wrap)
    );

    // R10: count holds while idle
    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) && !cnt_clr) |=> $stable(cnt_value));

    // R10: the machine enters RUN only after cnt_en was seen high
    a_r10_go: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_RUN) |-> $past(cnt_en));

endmodule

// File: tb/sim_icn_evcnt.sv
`timescale 1ns/1ps
module sim_icn_evcnt;

    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          txn_valid = 1'b0;
    logic [2:0]    txn_chan = '0;
    logic          txn_tag = 1'b0;
    logic [1:0]    txn_ring = '0;
    logic [7:0]    txn_event = '0;
    logic [2:0]    cfg_chan = '0;
    logic          cfg_tag_only = 1'b0;
    logic [1:0]    cfg_ring = '0;
    logic [7:0]    cfg_event = '0;
    logic          cnt_en = 1'b0;
    logic          cnt_clr = 1'b0;
    logic [CW-1:0] cnt_value;
    logic          cnt_wrap;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    icn_evcnt #(.CNT_W(CW), .EV_W(8)) u0 (
        .clk(clk), .rst_n(rst_n),
        .txn_valid(txn_valid), .txn_chan(txn_chan), .txn_tag(txn_tag),
        .txn_ring(txn_ring), .txn_event(txn_event),
        .cfg_chan(cfg_chan), .cfg_tag_only(cfg_tag_only),
        .cfg_ring(cfg_ring), .cfg_event(cfg_event),
        .cnt_en(cnt_en), .cnt_clr(cnt_clr),
        .cnt_value(cnt_value), .cnt_wrap(cnt_wrap)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic put(input logic v, input logic [2:0] c, input logic g,
                       input logic [1:0] r, input logic [7:0] e);
        txn_valid = v; txn_chan = c; txn_tag = g; txn_ring = r; txn_event = e;
    endtask

    // Expected hit computed from the requirement text
    function automatic bit model_hit(input int ce, input int to, input int cr,
                                     input int ev, input int c, input int g, input int r);
        bit chan_sel, pass_chan, pass_tag, in_rng, pass_ring;
        chan_sel  = (ce == 2) || (ce == 4) || (ce == 6) || (ce == 7);   // R2, R3
        pass_chan = !chan_sel || (c == ce);
        pass_tag  = (to == 0) || (g == 1);                               // R4
        in_rng    = (ev >= 'h47) && (ev <= 'h59);                        // R8
        if (cr == 0)      pass_ring = 1;                                 // R7
        else if (cr == 2) pass_ring = (r & 1) != 0;                      // R6
        else              pass_ring = (r & 2) != 0;                      // R5
        return pass_chan && pass_tag && (!in_rng || pass_ring);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int evs[5];
        evs = '{'h47, 'h59, 'h46, 'h5A, 'h50};
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1: reset state
        chk("R1 count", int'(cnt_value), 0);
        chk("R1 wrap", int'(cnt_wrap), 0);

        // R10: idle ignores hits; enable takes effect one edge later
        cfg_chan = 3'b000; cfg_ring = 2'b00; cfg_tag_only = 0; cfg_event = 8'h10;
        put(1, 3'd1, 0, 2'd0, 8'h10); cyc();
        chk("R10 idle holds", int'(cnt_value), 0);
        cnt_en = 1; cyc();                  // edge seen in IDLE: not counted
        chk("R10 first edge", int'(cnt_value), 0);
        cyc();                              // RUN: counted
        chk("R10 run counts", int'(cnt_value), 1);
        cnt_en = 0; cyc();                  // still RUN at this edge
        chk("R10 halt edge", int'(cnt_value), 2);
        cyc();                              // IDLE now
        chk("R10 after halt", int'(cnt_value), 2);

        // R11: clear wins over a simultaneous hit
        cnt_en = 1; cyc();
        cnt_clr = 1; cyc();
        cnt_clr = 0;
        chk("R11 clear priority", int'(cnt_value), 0);
        put(0, 0, 0, 0, 0); cyc();

        // Sweep: R2 R3 R4 R5 R6 R7 R8 R9
        for (int ce = 0; ce < 8; ce++)
          for (int to = 0; to < 2; to++)
            for (int cr = 0; cr < 4; cr++)
              for (int ei = 0; ei < 5; ei++) begin
                  int exp;
                  cfg_chan = 3'(ce); cfg_tag_only = 1'(to); cfg_ring = 2'(cr);
                  cfg_event = 8'(evs[ei]);
                  put(0, 0, 0, 0, 8'(evs[ei]));
                  cnt_clr = 1; cyc(); cnt_clr = 0;
                  exp = 0;
                  for (int c = 0; c < 8; c++)
                    for (int g = 0; g < 2; g++)
                      for (int r = 0; r < 4; r++) begin
                          put(1, 3'(c), 1'(g), 2'(r), 8'(evs[ei]));
                          if (model_hit(ce, to, cr, evs[ei], c, g, r)) exp++;
                          cyc();
                          put(1, 3'(c), 1'(g), 2'(r), 8'(evs[ei] ^ 1));  // R9 wrong code
                          cyc();
                          put(0, 3'(c), 1'(g), 2'(r), 8'(evs[ei]));      // R9 not valid
                          cyc();
                      end
                  chk($sformatf("R2 R3 R4 R5 R6 R7 R8 R9 chan=%0d tag=%0d ring=%0d ev=%0h",
                                ce, to, cr, evs[ei]), int'(cnt_value), exp);
              end

        // R12: wrap and sticky flag on the 8-bit instance
        cfg_chan = 3'b000; cfg_ring = 2'b00; cfg_tag_only = 0; cfg_event = 8'h10;
        put(0, 0, 0, 0, 8'h10);
        cnt_clr = 1; cyc(); cnt_clr = 0;
        put(1, 3'd3, 0, 2'd0, 8'h10);
        repeat (255) cyc();
        chk("R12 at all-ones", int'(cnt_value), 255);
        chk("R12 no wrap yet", int'(cnt_wrap), 0);
        cyc();
        chk("R12 wrapped count", int'(cnt_value), 0);
        chk("R12 wrap set", int'(cnt_wrap), 1);
        cyc();
        chk("R12 counting on", int'(cnt_value), 1);
        chk("R12 wrap sticky", int'(cnt_wrap), 1);
        put(0, 0, 0, 0, 8'h10);
        cnt_clr = 1; cyc(); cnt_clr = 0;
        chk("R11 clear count", int'(cnt_value), 0);
        chk("R11 clear wrap", int'(cnt_wrap), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule